// File: doc/BRIEF.md
# Per-Bank DRAM Row Timing Guard

This block sits between a memory controller's scheduler and the DRAM command bus. Each cycle the scheduler may present one command (open a row, read from the open row, or close the row) for one bank. The block either grants it, stalls it because the bank's timing window has not yet closed, or rejects it because it breaks the open/read/close order. A bank must see an open, then reads, then a close before it can be opened again. A granted read moves one 64-byte cache line, and that transfer is handled outside this block.

Every bank runs its own delay counter. Opening a row starts the row-open delay, and reads and the close command wait for it to expire. Closing a row starts the close delay, and the next open waits for it to expire. Both delays are 50 cycles in the nominal case. When the array runs at reduced voltage, some banks need longer delays. A per-bank configuration bit marks such a bank. A marked bank adds a per-bank whole number of 10-cycle steps to both delays. Unmarked banks keep the nominal delays. A bank's configuration is sampled when its row is opened. The delays for that open row and for the close that follows are then fixed, and changes made in the meantime apply from the next open onward.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset every bank reports closed (`bank_open` = 0) and ready (`bank_ready` all ones), and no request is granted until it is presented.
- R2: An open request (`req_cmd` = 1) to a bank that is closed and ready is granted in the cycle it is presented. From the next cycle the bank reports open and not ready.
- R3: A read (`req_cmd` = 2) to an open bank is stalled until its row-open delay D has elapsed. If the open was granted in cycle c, a read is stalled in cycles c+1 to c+D-1 and granted in cycle c+D.
- R4: A close request (`req_cmd` = 3) to an open bank waits for the same row-open delay. When it is granted, the bank reports closed. Another open to that bank is stalled until the close delay has elapsed, counted the same way as in R3.
- R5: Both delays are 50 cycles plus, only when the bank's `cfg_slow` bit is set, 10 cycles times that bank's step count. The step count sits at `cfg_steps[b*3 +: 3]`. An unmarked bank ignores its step count.
- R6: A bank samples its configuration when its open is granted. Changes made while the row is open alter neither that row's read and close timing nor the following close delay. They apply to the next open.
- R7: A read or close to a closed bank, or an open to an open bank, raises `reject` whatever the timers say. It is not granted, and no bank's open state changes.
- R8: Banks are timed independently. A command to one bank is granted while another bank is still inside its delay.
- R9: Any request with `req_valid` set and a command other than 0 raises exactly one of `grant`, `stall` and `reject`. Command 0 (no operation), or `req_valid` low, raises none of them.
- R10: `bank_ready` for a bank falls only in the cycle after an open or close to that bank is granted, and it rises again when that delay has run out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 2 | 0 none, 1 open row, 2 read, 3 close row |
| req_bank | input | 2 | Target bank index |
| cfg_slow | input | 4 | Per-bank mark: use lengthened delays |
| cfg_steps | input | 12 | Per-bank count of 10-cycle extension steps, 3 bits per bank |
| grant | output | 1 | The request is issued this cycle |
| stall | output | 1 | The request is legal but must wait |
| reject | output | 1 | The request breaks the command order |
| bank_open | output | 4 | Per-bank row-open state |
| bank_ready | output | 4 | Per-bank delay counter expired |

## Verification
The case that is hardest to reach is a configuration change that lands while a row is open. To see it, a bank has to be opened with nominal timing and then switched to the marked setting mid-row. The bench then times a full read, close and reopen cycle, and only the reopen after that shows the longer delay. The stimulus first opens a bank with nominal settings and then rewrites its mark and step count. It measures the read latency, the close-to-reopen latency and the next read latency as counts of stalled cycles. Independence between banks is reached by interleaving an open to a marked bank between the close and the reopen of a nominal bank, so that both counters run at once.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_OPEN  = 2'd1,
        CMD_READ  = 2'd2,
        CMD_CLOSE = 2'd3
    } bank_cmd_e;

endpackage

// File: rtl/bank_delay_pick.sv
module bank_delay_pick #(
    parameter int NOM_OPEN_CYC  = 50,
    parameter int NOM_CLOSE_CYC = 50,
    parameter int STEP_CYC      = 10,
    parameter int STEP_W        = 3,
    parameter int CNT_W         = 7
) (
    input  logic              slow,
    input  logic [STEP_W-1:0] steps,
    output logic [CNT_W-1:0]  open_dly,
    output logic [CNT_W-1:0]  close_dly
);

    logic [CNT_W-1:0] extra;

    always_comb begin
        extra     = slow ? CNT_W'(steps) * CNT_W'(STEP_CYC) : '0;
        open_dly  = CNT_W'(NOM_OPEN_CYC) + extra;
        close_dly = CNT_W'(NOM_CLOSE_CYC) + extra;
    end

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_go,
    input  logic             close_go,
    input  logic [CNT_W-1:0] open_dly,
    input  logic [CNT_W-1:0] close_dly,
    output logic             is_open,
    output logic             is_ready
);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] close_held;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (open_go) begin
            st_d.open       = 1'b1;
            st_d.cnt        = open_dly - CNT_W'(1);
            st_d.close_held = close_dly;
        end else if (close_go) begin
            st_d.open = 1'b0;
            st_d.cnt  = st_q.close_held - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_open  = st_q.open;
    assign is_ready = (st_q.cnt == '0);

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
    import bank_timing_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int NOM_OPEN_CYC  = 50,
    parameter int NOM_CLOSE_CYC = 50,
    parameter int STEP_CYC      = 10,
    parameter int STEP_W        = 3,
    localparam int BANK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int NOM_MAX = (NOM_OPEN_CYC > NOM_CLOSE_CYC) ? NOM_OPEN_CYC : NOM_CLOSE_CYC,
    localparam int MAX_DLY = NOM_MAX + ((1 << STEP_W) - 1) * STEP_CYC,
    localparam int CNT_W   = $clog2(MAX_DLY + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_cmd,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [NUM_BANKS-1:0]        cfg_slow,
    input  logic [NUM_BANKS*STEP_W-1:0] cfg_steps,
    output logic                        grant,
    output logic                        stall,
    output logic                        reject,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS-1:0]        bank_ready
);

    bank_cmd_e            cmd;
    logic                 active;
    logic                 legal;
    logic                 sel_open;
    logic                 sel_ready;
    logic [NUM_BANKS-1:0] open_go;
    logic [NUM_BANKS-1:0] close_go;

    always_comb begin
        cmd       = bank_cmd_e'(req_cmd);
        sel_open  = bank_open[req_bank];
        sel_ready = bank_ready[req_bank];
        active    = req_valid && (cmd != CMD_NONE);
        unique case (cmd)
            CMD_OPEN:  legal = !sel_open;
            CMD_READ:  legal = sel_open;
            CMD_CLOSE: legal = sel_open;
            default:   legal = 1'b0;
        endcase
        grant  = active && legal && sel_ready;
        stall  = active && legal && !sel_ready;
        reject = active && !legal;
        for (int b = 0; b < NUM_BANKS; b++) begin
            open_go[b]  = grant && (cmd == CMD_OPEN)  && (req_bank == BANK_W'(b));
            close_go[b] = grant && (cmd == CMD_CLOSE) && (req_bank == BANK_W'(b));
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [CNT_W-1:0] open_dly;
        logic [CNT_W-1:0] close_dly;

        bank_delay_pick #(
            .NOM_OPEN_CYC (NOM_OPEN_CYC),
            .NOM_CLOSE_CYC(NOM_CLOSE_CYC),
            .STEP_CYC     (STEP_CYC),
            .STEP_W       (STEP_W),
            .CNT_W        (CNT_W)
        ) u_pick (
            .slow     (cfg_slow[g]),
            .steps    (cfg_steps[g*STEP_W +: STEP_W]),
            .open_dly (open_dly),
            .close_dly(close_dly)
        );

        bank_tracker #(
            .CNT_W(CNT_W)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_go  (open_go[g]),
            .close_go (close_go[g]),
            .open_dly (open_dly),
            .close_dly(close_dly),
            .is_open  (bank_open[g]),
            .is_ready (bank_ready[g])
        );
    end

endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk
    import bank_timing_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           req_cmd,
    input logic [BANK_W-1:0]    req_bank,
    input logic                 grant,
    input logic                 stall,
    input logic                 reject,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_ready
);

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, stall, reject}));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(grant || stall || reject));

    a_r7_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> $stable(bank_open));

    a_r2_open_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == CMD_OPEN) |=>
            (bank_open[$past(req_bank)] && !bank_ready[$past(req_bank)]));

    a_r4_close_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == CMD_CLOSE) |=> !bank_open[$past(req_bank)]);

    a_r3_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_cmd == CMD_READ) |-> (bank_open[req_bank] && bank_ready[req_bank]));

    a_r10_ready_falls_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> ((bank_ready & $past(bank_ready)) == $past(bank_ready)));

    a_r8_open_changes_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> $stable(bank_open));

endmodule

bind bank_timing_guard bank_timing_guard_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .req_bank  (req_bank),
    .grant     (grant),
    .stall     (stall),
    .reject    (reject),
    .bank_open (bank_open),
    .bank_ready(bank_ready)
);

// File: tb/bank_timing_guard_test.sv
module bank_timing_guard_test;

    localparam int OUT_G = 0;
    localparam int OUT_S = 1;
    localparam int OUT_R = 2;
    localparam int OUT_N = 3;
    localparam int NV    = 16;

    // entry: {cmd[13:12], bank[11:10], idle cycles before[9:2], expected outcome[1:0]}
    localparam logic [13:0] VEC [NV] = '{
        {2'd1, 2'd0, 8'd0,  2'd0},  // open b0: granted               R2
        {2'd1, 2'd0, 8'd0,  2'd2},  // open to open b0: reject        R7
        {2'd2, 2'd0, 8'd0,  2'd1},  // read b0 k=2: stall             R3
        {2'd2, 2'd0, 8'd46, 2'd1},  // read b0 k=49: stall            R3
        {2'd2, 2'd0, 8'd0,  2'd0},  // read b0 k=50: grant            R3
        {2'd2, 2'd1, 8'd0,  2'd2},  // read closed b1: reject         R7
        {2'd3, 2'd2, 8'd0,  2'd2},  // close closed b2: reject        R7
        {2'd3, 2'd0, 8'd0,  2'd0},  // close b0: grant                R4
        {2'd1, 2'd0, 8'd0,  2'd1},  // reopen b0 k=1: stall           R4
        {2'd1, 2'd1, 8'd0,  2'd0},  // open b1 while b0 busy          R8
        {2'd1, 2'd0, 8'd46, 2'd1},  // reopen b0 k=49: stall          R4
        {2'd1, 2'd0, 8'd0,  2'd0},  // reopen b0 k=50: grant          R4
        {2'd2, 2'd1, 8'd0,  2'd1},  // read b1 k=49 (marked, 70)      R5
        {2'd2, 2'd1, 8'd19, 2'd1},  // read b1 k=69: stall            R5
        {2'd2, 2'd1, 8'd0,  2'd0},  // read b1 k=70: grant            R5
        {2'd0, 2'd2, 8'd0,  2'd3}   // valid no-op: nothing           R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = 2'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [3:0]  cfg_slow = 4'b0010;
    logic [11:0] cfg_steps = 12'b000_000_010_000;
    logic        grant, stall, reject;
    logic [3:0]  bank_open, bank_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bank_timing_guard uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_bank  (req_bank),
        .cfg_slow  (cfg_slow),
        .cfg_steps (cfg_steps),
        .grant     (grant),
        .stall     (stall),
        .reject    (reject),
        .bank_open (bank_open),
        .bank_ready(bank_ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input logic [1:0] b,
                         output int o);
        req_valid = v;
        req_cmd   = c;
        req_bank  = b;
        #2;
        o = grant ? OUT_G : stall ? OUT_S : reject ? OUT_R : OUT_N;
        if ((grant + stall + reject) > 1) o = 9;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        int o;
        for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 2'd0, o);
    endtask

    task automatic wait_grant(input logic [1:0] c, input logic [1:0] b, output int n);
        int o;
        n = 0;
        do begin
            drive(1'b1, c, b, o);
            n++;
        end while (o != OUT_G && n < 400);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int o;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R1 bank_open after reset", bank_open, 0);
        check("R1 bank_ready after reset", bank_ready, 15);
        check("R1 no grant when idle", grant, 0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            idle(int'(VEC[i][9:2]));
            drive(1'b1, VEC[i][13:12], VEC[i][11:10], o);
            check($sformatf("R2/R3/R4/R5/R7/R8/R9 vector %0d", i), o, int'(VEC[i][1:0]));
        end

        #2;
        check("R10 open state of banks", bank_open, 4'b0011);
        check("R10 ready bit of busy bank 0", bank_ready[0], 0);
        check("R10 ready bit of expired bank 1", bank_ready[1], 1);
        @(negedge clk);

        // R5: marked bank close delay is also 70
        wait_grant(2'd3, 2'd1, n);
        check("R5 close b1 immediate", n, 1);
        wait_grant(2'd1, 2'd1, n);
        check("R5 marked close delay", n, 70);
        wait_grant(2'd2, 2'd1, n);
        check("R5 marked open delay", n, 70);

        // R6: config change while the row is open
        wait_grant(2'd1, 2'd2, n);
        check("R6 open b2 immediate", n, 1);
        cfg_slow[2] = 1'b1;
        cfg_steps[8:6] = 3'd3;
        wait_grant(2'd2, 2'd2, n);
        check("R6 read keeps nominal delay", n, 50);
        wait_grant(2'd3, 2'd2, n);
        check("R6 close immediate", n, 1);
        wait_grant(2'd1, 2'd2, n);
        check("R6 close delay stays nominal", n, 50);
        wait_grant(2'd2, 2'd2, n);
        check("R6 new setting at next open", n, 80);

        // R5: unmarked bank ignores its step count
        cfg_steps[11:9] = 3'd7;
        wait_grant(2'd1, 2'd3, n);
        check("R5 open b3 immediate", n, 1);
        wait_grant(2'd2, 2'd3, n);
        check("R5 unmarked ignores steps", n, 50);

        // R9: request with valid low
        drive(1'b0, 2'd1, 2'd0, o);
        check("R9 valid low gives no outcome", o, OUT_N);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        @(negedge clk);
        #2;
        check("R1 reset closes banks", bank_open, 0);
        check("R1 reset readies banks", bank_ready, 15);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b1, 2'd1, 2'd3, o);
        check("R1 R2 open right after reset", o, OUT_G);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule